// File: doc/BRIEF.md
# RTC Square-Wave / Alarm-Interrupt Pin Controller

This block drives the single shared output pin of a real-time clock. It runs on the oscillator clock and holds an 8-bit control word. That word stops the oscillator on backup power, keeps the pin alive on backup power, picks one of four square-wave rates, switches the pin between square-wave mode and interrupt mode, and gates the alarm interrupt. The block also holds the alarm flag.

In square-wave mode the pin carries a divided copy of the oscillator. In interrupt mode the pin is an active-low request that follows the alarm flag when the alarm interrupt is enabled. The pin is modelled as a data bit plus an output enable. The enable drops when the part runs from backup power and backup output has not been allowed.

The clock input `clk` runs at twice the oscillator rate. The divider is a free-running counter of `SLOW_TAP+1` bits, and each rate is one bit of that counter.

Top module: `rtc_sqw_alarm_out`

## Requirements
- R1: After reset the control read-back is 8'h18 (rate code 11, every other field 0), the alarm flag is 0, the pin output enable is 1 on main power, and the divider count is 0.
- R2: Control bits 6 and 1 always read back 0, whatever value is written. Writing 8'h42 reads back 8'h00, and writing 8'hFF reads back 8'hBD.
- R3: Control bits [4:3] hold the rate code. In square-wave mode (bit 2 = 0) with the oscillator running, the pin equals bit t of the count of running clock edges since reset. t is SLOW_TAP for code 00 (1 Hz), 3 for 01 (4.096 kHz), 2 for 10 (8.192 kHz) and 0 for 11 (32.768 kHz).
- R4: A new rate code takes effect only at the clock edge where the divider count wraps to zero, so neither the old rate nor the new rate produces a phase shorter than its own half period.
- R5: Bit 7 = 1 on backup power stops the oscillator. The divider count then holds, the pin sits at 1 in square-wave mode, and counting resumes from the held value when the oscillator restarts.
- R6: On main power (on_backup = 0) the oscillator runs whatever value bit 7 holds.
- R7: Every alarm_match pulse sets the alarm flag one edge later, whatever the mode and enable bits hold.
- R8: With bit 2 = 1 and bit 0 = 1, a set alarm flag drives the pin to 0. The pin stays at 0 until a flag_clr pulse clears the flag.
- R9: If bit 0 = 0 or bit 2 = 0, the alarm flag does not reach the pin. In interrupt mode the pin then stays at 1. In square-wave mode the pin keeps following the R3 wave.
- R10: pin_oe is 1 on main power. On backup power pin_oe equals control bit 5.
- R11: When alarm_match and flag_clr arrive in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator rate |
| rst_n | input | 1 | Synchronous reset, active low |
| on_backup | input | 1 | 1 while running from backup power |
| ctl_wr_en | input | 1 | Writes ctl_wr_data into the control word |
| ctl_wr_data | input | 8 | Control word value to write |
| ctl_rd_data | output | 8 | Current control word |
| alarm_match | input | 1 | One-cycle alarm comparison hit |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Alarm flag state |
| pin_out | output | 1 | Data value of the shared pin |
| pin_oe | output | 1 | Output enable of the shared pin |

## Verification
The bench builds the block with SLOW_TAP = 5. The slowest rate then has a 64-cycle period, and a whole divider wrap fits in a few dozen cycles. This makes the deferred rate switch at the wrap observable for all four rate codes, both before and after the switch, in every cycle. The fast taps stay at their default positions, so the 4.096 kHz and 8.192 kHz waves are checked at their real divide ratios. The oscillator is stopped and restarted mid-count, which shows that the held count resumes in phase.

// File: rtl/rtc_sqw_pkg.sv
// Package: shared control-word layout and rate codes for the RTC pin controller.
// Assumes an 8-bit control word in which bits 6 and 1 are unimplemented.
package rtc_sqw_pkg;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    typedef struct packed {
        logic  osc_off;    // bit 7: stop oscillator while on backup
        logic  rsvd6;      // bit 6: unimplemented
        logic  batt_out;   // bit 5: keep pin driven on backup
        rate_e rate;       // bits 4:3: square-wave rate
        logic  int_mode;   // bit 2: 1 = interrupt, 0 = square wave
        logic  rsvd1;      // bit 1: unimplemented
        logic  alm_ie;     // bit 0: alarm interrupt enable
    } ctl_t;

    localparam logic [7:0] CTL_RESET     = 8'h18;
    localparam logic [7:0] CTL_LIVE_MASK = 8'hBD;

endpackage

// File: rtl/rtc_ctl_reg.sv
// Module: control word and alarm flag storage.
// Assumes writes and flag clears arrive as single-cycle strobes in the clk domain.
// Unimplemented bits are masked on write, so they always read 0.
module rtc_ctl_reg
    import rtc_sqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       alarm_match,
    input  logic       flag_clr,
    output logic [7:0] rd_data,
    output logic       osc_off,
    output logic       batt_out,
    output rate_e      rate,
    output logic       int_mode,
    output logic       alm_ie,
    output logic       alarm_flag
);

    ctl_t ctl_q;
    logic flag_q;

    // Control word: reset to defaults, load masked write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= ctl_t'(CTL_RESET);
        else if (wr_en)
            ctl_q <= ctl_t'(wr_data & CTL_LIVE_MASK);
    end

    // Alarm flag: a match sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (alarm_match)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // Field breakout for the downstream logic.
    always_comb begin
        rd_data    = ctl_q;
        osc_off    = ctl_q.osc_off;
        batt_out   = ctl_q.batt_out;
        rate       = ctl_q.rate;
        int_mode   = ctl_q.int_mode;
        alm_ie     = ctl_q.alm_ie;
        alarm_flag = flag_q;
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_match |=> alarm_flag);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);

endmodule

// File: rtl/rtc_sqw_div.sv
// Module: oscillator divider and rate tap selection.
// Assumes clk runs at twice the oscillator rate, so counter bit k toggles at
// osc/2^k. The requested rate is adopted only when the counter wraps, where
// every tap starts a fresh low phase.
module rtc_sqw_div
    import rtc_sqw_pkg::*;
#(
    parameter int SLOW_TAP = 15,
    parameter int TAP_4K   = 3,
    parameter int TAP_8K   = 2,
    parameter int TAP_32K  = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  osc_run,
    input  rate_e rate_req,
    output logic  sq_wave
);

    localparam int              CNT_W   = SLOW_TAP + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    function automatic int tap_of(input int code);
        case (code)
            0:       return SLOW_TAP;
            1:       return TAP_4K;
            2:       return TAP_8K;
            default: return TAP_32K;
        endcase
    endfunction

    logic [CNT_W-1:0] cnt_q;
    rate_e            act_rate_q;
    logic [3:0]       tap_bits;

    // Divider counter: advances only while the oscillator runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (osc_run)
            cnt_q <= cnt_q + 1'b1;
    end

    // Active rate: take the requested code at the wrap edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_rate_q <= RATE_32K;
        else if (osc_run && cnt_q == CNT_MAX)
            act_rate_q <= rate_req;
    end

    // One tap per rate code, picked from the counter.
    for (genvar r = 0; r < 4; r++) begin : g_tap
        assign tap_bits[r] = cnt_q[tap_of(r)];
    end

    // Output select from the active rate.
    always_comb sq_wave = tap_bits[act_rate_q];

    // R5
    div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> $stable(cnt_q));

    // R4
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> $stable(act_rate_q));

endmodule

// File: rtl/rtc_pin_mux.sv
// Module: shared pin data and enable.
// Assumes all inputs are registered or static, so the outputs are pure
// combinational decode. Square-wave mode holds the pin high while stopped.
module rtc_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic on_backup,
    input  logic osc_off,
    input  logic batt_out,
    input  logic int_mode,
    input  logic alm_ie,
    input  logic alarm_flag,
    input  logic sq_wave,
    output logic osc_run,
    output logic pin_out,
    output logic pin_oe
);

    // Oscillator gate: stop allowed only on backup power.
    always_comb osc_run = !(osc_off && on_backup);

    // Pin data: active-low alarm request, or the gated square wave.
    always_comb begin
        if (int_mode)
            pin_out = !(alm_ie && alarm_flag);
        else
            pin_out = osc_run ? sq_wave : 1'b1;
    end

    // Pin enable: always on main power, by the backup enable otherwise.
    always_comb pin_oe = !on_backup || batt_out;

    // R10
    oe_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_backup |-> pin_oe);

    // R9
    flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && !alm_ie && alarm_flag) |-> pin_out);

endmodule

// File: rtl/rtc_sqw_alarm_out.sv
// Module: top of the RTC shared-pin controller.
// Assumes clk at twice the oscillator rate and a synchronous active-low reset.
// Wires the control storage, divider and pin decode together.
module rtc_sqw_alarm_out
    import rtc_sqw_pkg::*;
#(
    parameter int SLOW_TAP = 15,
    parameter int TAP_4K   = 3,
    parameter int TAP_8K   = 2,
    parameter int TAP_32K  = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_backup,
    input  logic       ctl_wr_en,
    input  logic [7:0] ctl_wr_data,
    output logic [7:0] ctl_rd_data,
    input  logic       alarm_match,
    input  logic       flag_clr,
    output logic       alarm_flag,
    output logic       pin_out,
    output logic       pin_oe
);

    logic  osc_off, batt_out, int_mode, alm_ie, osc_run, sq_wave;
    rate_e rate;

    rtc_ctl_reg i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .alarm_match (alarm_match),
        .flag_clr    (flag_clr),
        .rd_data     (ctl_rd_data),
        .osc_off     (osc_off),
        .batt_out    (batt_out),
        .rate        (rate),
        .int_mode    (int_mode),
        .alm_ie      (alm_ie),
        .alarm_flag  (alarm_flag)
    );

    rtc_sqw_div #(
        .SLOW_TAP (SLOW_TAP),
        .TAP_4K   (TAP_4K),
        .TAP_8K   (TAP_8K),
        .TAP_32K  (TAP_32K)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_run  (osc_run),
        .rate_req (rate),
        .sq_wave  (sq_wave)
    );

    rtc_pin_mux i_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_backup  (on_backup),
        .osc_off    (osc_off),
        .batt_out   (batt_out),
        .int_mode   (int_mode),
        .alm_ie     (alm_ie),
        .alarm_flag (alarm_flag),
        .sq_wave    (sq_wave),
        .osc_run    (osc_run),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // R6
    osc_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_backup |-> osc_run);

endmodule

// File: tb/test_rtc_sqw_alarm_out.sv
`timescale 1ns/1ps
module test_rtc_sqw_alarm_out;

    localparam int SLOW_TAP = 5;
    localparam int M        = 1 << (SLOW_TAP + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       on_backup = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic [7:0] ctl_rd_data;
    logic       alarm_match = 1'b0;
    logic       flag_clr = 1'b0;
    logic       alarm_flag, pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Independent bench model of the requirements.
    int         n = 0;
    int         act_tap = 0;
    int         pend_tap = 0;
    logic [7:0] m_ctl = 8'h18;
    logic       m_flag = 1'b0;

    always #4 clk = ~clk;

    rtc_sqw_alarm_out #(.SLOW_TAP(SLOW_TAP)) i_rtc_sqw_alarm_out (
        .clk(clk), .rst_n(rst_n), .on_backup(on_backup),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .alarm_match(alarm_match), .flag_clr(flag_clr), .alarm_flag(alarm_flag),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Vector: {req[3:0], bk, we, wd[7:0], am, fc, exp_pin, exp_oe, exp_flag}
    localparam int NV = 13;
    localparam logic [18:0] VEC [NV] = '{
        {4'd8,  1'b0, 1'b1, 8'h1D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 enter interrupt mode
        {4'd7,  1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 match sets flag
        {4'd8,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 held low
        {4'd8,  1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 clear releases
        {4'd9,  1'b0, 1'b1, 8'h1C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 enable off
        {4'd7,  1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 flag set, pin quiet
        {4'd9,  1'b0, 1'b1, 8'h1D, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 enable on
        {4'd11, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R11 set beats clear
        {4'd10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 backup, no enable
        {4'd10, 1'b1, 1'b1, 8'h3D, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 backup enable on
        {4'd10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R10 main power
        {4'd10, 1'b1, 1'b1, 8'h1D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 backup enable off
        {4'd10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R10 back on main
    };

    function automatic int tap_of(input logic [1:0] code);
        case (code)
            2'b00:   return SLOW_TAP;
            2'b01:   return 3;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    endtask

    // One clock with the given inputs, the model advanced at the edge.
    task automatic step(input logic bk, input logic we, input logic [7:0] wd,
                        input logic am, input logic fc);
        on_backup = bk; ctl_wr_en = we; ctl_wr_data = wd; alarm_match = am; flag_clr = fc;
        @(posedge clk);
        if (!(m_ctl[7] && bk)) begin
            if (((n + 1) % M) == 0) act_tap = pend_tap;
            n++;
        end
        if (am) m_flag = 1'b1;
        else if (fc) m_flag = 1'b0;
        if (we) begin
            m_ctl = wd & 8'hBD;
            pend_tap = tap_of(m_ctl[4:3]);
        end
        @(negedge clk);
    endtask

    // Compare pin, enable and flag against the model.
    task automatic check_model(input string tag);
        logic run, e_pin, e_oe;
        run   = !(m_ctl[7] && on_backup);
        e_oe  = !on_backup || m_ctl[5];
        if (m_ctl[2]) e_pin = !(m_ctl[0] && m_flag);
        else          e_pin = run ? n[act_tap] : 1'b1;
        check(tag, {5'd0, pin_out, pin_oe, alarm_flag}, {5'd0, e_pin, e_oe, m_flag});
    endtask

    task automatic run_idle(input int cycles, input logic bk, input string tag);
        for (int i = 0; i < cycles; i++) begin
            step(bk, 1'b0, 8'h00, 1'b0, 1'b0);
            check_model(tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        // Reset: three edges low, release at a falling edge.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ctl reset", ctl_rd_data, 8'h18);
        check("R1 flag/oe/pin reset", {5'd0, pin_out, pin_oe, alarm_flag}, 8'h02);

        // R3 fastest rate from reset
        run_idle(10, 1'b0, "R3 rate 11");

        // R4 / R3 rate 10, deferred to wrap
        step(1'b0, 1'b1, 8'h10, 1'b0, 1'b0); check_model("R4 write 10");
        run_idle(2 * M, 1'b0, "R4 rate 10");
        // R3 rate 01
        step(1'b0, 1'b1, 8'h08, 1'b0, 1'b0); check_model("R4 write 01");
        run_idle(2 * M, 1'b0, "R3 rate 01");
        // R3 rate 00 (slow tap)
        step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0); check_model("R4 write 00");
        run_idle(2 * M + 3, 1'b0, "R3 rate 00");
        step(1'b0, 1'b1, 8'h18, 1'b0, 1'b0); check_model("R4 write 11");
        run_idle(M + 5, 1'b0, "R4 back to 11");

        // Table walk: interrupt mode, flag and enable behaviour.
        for (int v = 0; v < NV; v++) begin
            logic [18:0] e;
            string tag;
            e = VEC[v];
            step(e[14], e[13], e[12:5], e[4], e[3]);
            tag = $sformatf("R%0d row %0d", e[18:15], v);
            check(tag, {5'd0, pin_out, pin_oe, alarm_flag}, {5'd0, e[2:0]});
        end

        // R9 square-wave mode ignores a set flag.
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0); check_model("R7 set flag");
        step(1'b0, 1'b1, 8'h19, 1'b0, 1'b0); check_model("R9 sq mode aie");
        run_idle(8, 1'b0, "R9 flag not on pin");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1); check_model("R8 clear");

        // R6 stop bit on main power: still runs.
        step(1'b0, 1'b1, 8'h98, 1'b0, 1'b0); check_model("R6 write stop");
        run_idle(10, 1'b0, "R6 runs on main");
        // R5 stop on backup with output kept alive.
        step(1'b0, 1'b1, 8'hB8, 1'b0, 1'b0); check_model("R5 write");
        run_idle(10, 1'b1, "R5 stopped");
        run_idle(10, 1'b0, "R5 resume");

        // R2 unimplemented bits.
        step(1'b0, 1'b1, 8'h42, 1'b0, 1'b0);
        check("R2 write 42", ctl_rd_data, 8'h00);
        step(1'b0, 1'b1, 8'hFF, 1'b0, 1'b0);
        check("R2 write FF", ctl_rd_data, 8'hBD);

        report();
    end

endmodule